// File: doc/BRIEF.md
# Component video 4:2:2 output formatter

This block sits at the tail of a component video digitizer and shapes the per-pixel sample stream before it leaves the chip. Each pixel arrives as three 8-bit samples with a valid strobe: luma on the green lane, the blue-difference sample (U) on the blue lane and the red-difference sample (V) on the red lane. A line-start flag marks the first pixel of each line. The samples carry no colour-space conversion.

With 4:2:2 output disabled, all three lanes pass to the output unchanged. With 4:2:2 enabled, luma stays on green and blue is forced to zero. Red then carries a single chroma lane that alternates U and V. Chroma is decimated by picking samples, not by filtering. The co-sited ordering takes both chroma samples from the even pixel of each pair: U0 V0 U2 V2. The alternate-phase ordering, chosen by a separate enable, takes each sample from the pixel it travels with: U0 V1 U2 V3. Every output is registered, so there is one cycle of latency.

Top module: `yc422_formatter`

## Requirements
- R1: While reset is asserted, and until the first valid pixel after release, out_valid is 0 and out_r, out_g and out_b are all zero.
- R2: out_valid in cycle n+1 equals in_valid in cycle n.
- R3: With cfg_422 = 0, a valid pixel appears one cycle later with out_r = in_r, out_g = in_g and out_b = in_b. cfg_compat has no effect in this mode.
- R4: With cfg_422 = 1, a valid pixel's in_g appears unchanged on out_g one cycle later.
- R5: With cfg_422 = 1, out_b is zero one cycle after every valid pixel.
- R6: With cfg_422 = 1 and cfg_compat = 0, an even pixel puts its own in_b (U) on out_r. An odd pixel puts on out_r the in_r (V) captured on the most recent even valid pixel.
- R7: With cfg_422 = 1 and cfg_compat = 1, an even pixel puts its own in_b (U) on out_r and an odd pixel puts its own in_r (V) on out_r.
- R8: Pixel parity toggles on every valid pixel. A valid pixel that arrives with line_start high is even. A line_start pulse without in_valid makes the next valid pixel even.
- R9: In a cycle with in_valid = 0, the data outputs keep the values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| in_valid | input | 1 | Pixel strobe for in_r, in_g and in_b |
| line_start | input | 1 | First pixel of a line (or, without in_valid, restart parity) |
| in_r | input | DW | Red-difference sample (V) |
| in_g | input | DW | Luma sample (Y) |
| in_b | input | DW | Blue-difference sample (U) |
| cfg_422 | input | 1 | 1 selects 4:2:2 output, 0 selects 4:4:4 pass-through |
| cfg_compat | input | 1 | 1 selects alternate-phase chroma in 4:2:2 mode |
| out_valid | output | 1 | Output pixel strobe |
| out_r | output | DW | Chroma lane (4:2:2) or V (4:4:4) |
| out_g | output | DW | Luma |
| out_b | output | DW | Zero (4:2:2) or U (4:4:4) |

## Verification
The assertions assume that every input is a known value at each rising edge after reset. They also assume the mode bits are sampled in the same cycle as the pixel they govern, so a mode change takes effect on the next valid pixel. No other framing is assumed: line_start may arrive with or without in_valid, and lines may have odd lengths. The stimulus drives every input at the falling edge and keeps them all known. It holds in_valid low through reset. It changes modes on arbitrary cycles, and the bench's reference model follows those changes pixel by pixel.

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;

  localparam int PIX_W = 8;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    FMT_444        = 2'd0,
    FMT_422_COSITE = 2'd1,
    FMT_422_ALT    = 2'd2
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic en_422, input logic en_alt);
    if (!en_422)     return FMT_444;
    else if (en_alt) return FMT_422_ALT;
    else             return FMT_422_COSITE;
  endfunction

  function automatic phase_e flip_phase(input phase_e p);
    return (p == PH_EVEN) ? PH_ODD : PH_EVEN;
  endfunction

endpackage

// File: rtl/yc_rst_sync.sv
module yc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/yc_phase_track.sv
module yc_phase_track
  import yc_fmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pix_vld,
  input  logic   line_start,
  output phase_e cur_phase
);

  phase_e phase_q;
  phase_e phase_d;

  // line start forces the present pixel (or the next one) to even
  always_comb begin
    cur_phase = line_start ? PH_EVEN : phase_q;
    phase_d   = pix_vld ? flip_phase(cur_phase) : cur_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_EVEN;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/yc_chroma_sel.sv
module yc_chroma_sel
  import yc_fmt_pkg::*;
#(
  parameter int DW = PIX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  phase_e        cur_phase,
  input  fmt_e          fmt,
  input  logic [DW-1:0] u_in,
  input  logic [DW-1:0] v_in,
  output logic [DW-1:0] chroma
);

  logic [DW-1:0] v_hold_q;
  logic [DW-1:0] v_hold_d;
  logic          hold_en;

  always_comb begin
    hold_en  = pix_vld && (cur_phase == PH_EVEN);
    v_hold_d = v_in;
    if (cur_phase == PH_EVEN)      chroma = u_in;
    else if (fmt == FMT_422_ALT)   chroma = v_in;
    else                           chroma = v_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       v_hold_q <= '0;
    else if (hold_en) v_hold_q <= v_hold_d;
  end

endmodule

// File: rtl/yc422_formatter.sv
module yc422_formatter
  import yc_fmt_pkg::*;
#(
  parameter int DW          = PIX_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          line_start,
  input  logic [DW-1:0] in_r,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  input  logic          cfg_422,
  input  logic          cfg_compat,
  output logic          out_valid,
  output logic [DW-1:0] out_r,
  output logic [DW-1:0] out_g,
  output logic [DW-1:0] out_b
);

  logic          rst_n_s;
  phase_e        cur_phase;
  fmt_e          fmt;
  logic [DW-1:0] chroma;
  logic [DW-1:0] r_d, g_d, b_d;
  logic          data_en;

  yc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  yc_phase_track u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pix_vld    (in_valid),
    .line_start (line_start),
    .cur_phase  (cur_phase)
  );

  yc_chroma_sel #(.DW(DW)) u_chroma (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pix_vld   (in_valid),
    .cur_phase (cur_phase),
    .fmt       (fmt),
    .u_in      (in_b),
    .v_in      (in_r),
    .chroma    (chroma)
  );

  always_comb begin
    fmt     = decode_fmt(cfg_422, cfg_compat);
    data_en = in_valid;
    g_d     = in_g;
    if (fmt == FMT_444) begin
      r_d = in_r;
      b_d = in_b;
    end else begin
      r_d = chroma;
      b_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (data_en) begin
        out_r <= r_d;
        out_g <= g_d;
        out_b <= b_d;
      end
    end
  end

endmodule

// File: rtl/yc422_checker.sv
module yc422_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_r,
  input logic [DW-1:0] in_g,
  input logic [DW-1:0] in_b,
  input logic          cfg_422,
  input logic          out_valid,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2

  AST_PASS_444: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_422) |=> (out_r == $past(in_r) && out_b == $past(in_b)));  // R3

  AST_LUMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_g == $past(in_g)));  // R4

  AST_BLUE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_422) |=> (out_b == '0));  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({out_r, out_g, out_b}));  // R9

endmodule

bind yc422_formatter yc422_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .in_valid  (in_valid),
  .in_r      (in_r),
  .in_g      (in_g),
  .in_b      (in_b),
  .cfg_422   (cfg_422),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b)
);

// File: tb/tb_yc422_formatter.sv
module tb_yc422_formatter;

  logic       clk;
  logic       rst_n;
  logic       in_valid, line_start, cfg_422, cfg_compat;
  logic [7:0] in_r, in_g, in_b;
  logic       out_valid;
  logic [7:0] out_r, out_g, out_b;

  int  n_chk;
  int  n_err;
  bit  done;

  // reference model state
  bit         m_odd;
  logic [7:0] m_vhold;
  logic [7:0] e_r, e_g, e_b;

  yc422_formatter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .cfg_422(cfg_422), .cfg_compat(cfg_compat),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_red(input bit m422, input bit alt, input bit odd,
                                         input logic [7:0] r, input logic [7:0] b,
                                         input logic [7:0] hold);
    if (!m422)     return r;
    else if (!odd) return b;
    else if (alt)  return r;
    else           return hold;
  endfunction

  // called just after a falling edge: drive, model, wait one edge, check
  task automatic cycle(input bit v, input bit ls, input bit m422, input bit alt,
                       input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    bit ph;
    in_valid = v; line_start = ls; cfg_422 = m422; cfg_compat = alt;
    in_r = r; in_g = g; in_b = b;
    if (v) begin
      ph  = ls ? 1'b0 : m_odd;
      e_r = exp_red(m422, alt, ph, r, b, m_vhold);
      e_g = g;
      e_b = m422 ? 8'd0 : b;
      if (!ph) m_vhold = r;
      m_odd = ~ph;
    end else if (ls) begin
      m_odd = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == v, "R2", out_valid, v);
    if (!v) begin
      chk(out_r == e_r && out_g == e_g && out_b == e_b, "R9",
          {out_r, out_g, out_b}, {e_r, e_g, e_b});
    end else if (!m422) begin
      chk(out_r == e_r && out_g == e_g && out_b == e_b, "R3",
          {out_r, out_g, out_b}, {e_r, e_g, e_b});
    end else begin
      chk(out_g == e_g, "R4", out_g, e_g);
      chk(out_b == 8'd0, "R5", out_b, 0);
      if (alt) chk(out_r == e_r, "R7", out_r, e_r);
      else     chk(out_r == e_r, "R6", out_r, e_r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    n_chk = 0; n_err = 0; done = 0;
    m_odd = 0; m_vhold = '0; e_r = '0; e_g = '0; e_b = '0;
    rst_n = 1'b0; in_valid = 0; line_start = 0; cfg_422 = 0; cfg_compat = 0;
    in_r = 8'h11; in_g = 8'h22; in_b = 8'h33;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0, "R1",
        {out_valid, out_r, out_g, out_b}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && out_r == 0 && out_g == 0 && out_b == 0, "R1",
        {out_valid, out_r, out_g, out_b}, 0);

    // R7: alternate-phase chroma on a short line
    cycle(1, 1, 1, 1, 8'd10, 8'd50, 8'd20);
    chk(out_r == 8'd20, "R7", out_r, 20);
    cycle(1, 0, 1, 1, 8'd11, 8'd51, 8'd21);
    chk(out_r == 8'd11, "R7", out_r, 11);
    cycle(1, 0, 1, 1, 8'd12, 8'd52, 8'd22);
    chk(out_r == 8'd22, "R7", out_r, 22);

    // R6: co-sited chroma, odd pixel repeats even V
    cycle(1, 1, 1, 0, 8'd10, 8'd50, 8'd20);
    chk(out_r == 8'd20, "R6", out_r, 20);
    cycle(0, 0, 1, 0, 8'd99, 8'd99, 8'd99);
    cycle(1, 0, 1, 0, 8'd11, 8'd51, 8'd21);
    chk(out_r == 8'd10, "R6", out_r, 10);

    // R8: odd-length line, line_start with valid restarts on even
    cycle(1, 0, 1, 0, 8'd30, 8'd60, 8'd40);
    cycle(1, 1, 1, 0, 8'd31, 8'd61, 8'd41);
    chk(out_r == 8'd41, "R8", out_r, 41);
    // line_start alone makes next valid pixel even
    cycle(0, 1, 1, 0, 8'd0, 8'd0, 8'd0);
    cycle(1, 0, 1, 0, 8'd32, 8'd62, 8'd42);
    chk(out_r == 8'd42, "R8", out_r, 42);
    cycle(1, 0, 1, 0, 8'd33, 8'd63, 8'd43);
    chk(out_r == 8'd32, "R8", out_r, 32);

    // R3: 4:4:4 pass-through, compat bit ignored
    cycle(1, 1, 0, 1, 8'd70, 8'd80, 8'd90);
    chk(out_r == 8'd70 && out_b == 8'd90, "R3", {out_r, out_b}, {8'd70, 8'd90});
    cycle(1, 0, 0, 1, 8'd71, 8'd81, 8'd91);
    chk(out_r == 8'd71 && out_b == 8'd91, "R3", {out_r, out_b}, {8'd71, 8'd91});

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit v, ls, m4, al;
      v  = ($urandom_range(0, 3) != 0);
      ls = ($urandom_range(0, 11) == 0);
      m4 = ($urandom_range(0, 2) != 0);
      al = ($urandom_range(0, 1) == 1);
      cycle(v, ls, m4, al, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    in_valid = 0; line_start = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule